// File: doc/BRIEF.md
# Serial DAC Sample Feeder

This block streams 8-bit samples to a bit-serial DAC. A writer on the fast system clock places samples in a small FIFO. A fetch stage moves one sample at a time from the FIFO into a holding register, and only when the serializer asks for one. The serializer shifts each sample out one bit at a time and marks the start of every frame with a load strobe.

The DAC bit rate comes from a slow clock that is unrelated to the system clock. That slow clock never clocks a register. It is sampled as data by a three-flop chain on the fast clock. Each rising edge turns into a single fast-cycle enable, so the whole block lives in one clock domain.

When no sample is ready at the start of a frame, the serializer sends a frame of zeros and raises a sticky underrun flag. Only reset clears that flag.

Top module: `dacf_top`

## Requirements
- R1: After reset, `full`, `ser_data`, `ser_load` and `underrun` are all 0.
- R2: `slow_clk` passes through three fast-clock flops. The serializer advances exactly one bit per rising edge of `slow_clk` and never on a falling edge. A rise that is present at fast edge k shows on the serial outputs after fast edge k+2.
- R3: Each sample goes out as 8 bits, most significant bit first, on `ser_data`. Samples leave in the order they were written, and frames follow one another with no gap.
- R4: `ser_load` is 1 for the enable period that carries bit 7 of a frame and 0 for the other seven bit periods.
- R5: If no sample is held when a frame starts, that frame sends eight 0 bits. `underrun` then goes to 1 and stays 1 until reset.
- R6: The FIFO holds 16 samples. `full` is 1 exactly when 16 samples are stored.
- R7: A write while `full` is 1 is ignored. The rejected value never appears on `ser_data`.
- R8: The fetch stage uses a level request/acknowledge. It takes one sample from the FIFO only while the serializer requests one and the holding register is empty. This gives one transfer per frame, with none lost and none doubled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| wr_en | input | 1 | Write strobe for the FIFO |
| wr_data | input | 8 | Sample to write |
| full | output | 1 | FIFO holds 16 samples |
| slow_clk | input | 1 | Asynchronous DAC bit clock |
| ser_data | output | 1 | Serial data to the DAC, MSB first |
| ser_load | output | 1 | Frame start strobe, one bit period wide |
| underrun | output | 1 | Sticky: a frame started with no sample held |

## Verification
The bench builds the block with its defaults: a 16-entry FIFO and a 3-stage synchronizer. With a depth of 16, the bench reaches the full state after 17 writes, because one sample already sits in the holding register. That lets it test a rejected write and then drain the whole backlog. With three stages, the two-cycle latency from a slow-clock edge to the output is fixed. The bench can therefore run slow-clock high phases as short as two fast cycles, with asymmetric duty. It can also run writes concurrently with an underrun and a recovery.

// File: rtl/dacf_pkg.sv
package dacf_pkg;
  localparam int unsigned SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/dacf_edge_sync.sv
// Samples an asynchronous level through a flop chain and flags its rising edge.
module dacf_edge_sync #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_en
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // second-to-last stage high while last stage still low: one cycle per rise
  assign rise_en = chain_q[STAGES-2] & ~chain_q[STAGES-1];
endmodule

// File: rtl/dacf_fifo.sv
module dacf_fifo
  import dacf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  sample_t       push_data,
  input  logic          pop,
  output sample_t       head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] fill
);
  sample_t         mem_q [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign fill    = cnt_q;
  assign head    = mem_q[rd_q];
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  always_comb begin
    wr_d  = push_ok ? bump(wr_q) : wr_q;
    rd_d  = pop_ok  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/dacf_fetch.sv
// Moves one sample from the FIFO into the holding register per request.
module dacf_fetch
  import dacf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    fifo_empty,
  input  sample_t fifo_head,
  output logic    fifo_pop,
  input  logic    take,
  output sample_t hold_data,
  output logic    hold_vld
);
  sample_t hold_q;
  logic    vld_q, vld_d;

  assign fifo_pop  = req & ~vld_q & ~fifo_empty;
  assign hold_data = hold_q;
  assign hold_vld  = vld_q;

  always_comb begin
    vld_d = vld_q;
    if (fifo_pop)  vld_d = 1'b1;
    else if (take) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (fifo_pop) hold_q <= fifo_head;
  end
endmodule

// File: rtl/dacf_serializer.sv
module dacf_serializer
  import dacf_pkg::*;
#(
  localparam int unsigned BW = $clog2(SAMPLE_W)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  sample_t hold_data,
  input  logic    hold_vld,
  output logic    take,
  output logic    req,
  output logic    ser_data,
  output logic    ser_load,
  output logic    underrun
);
  sample_t       shift_q, shift_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          load_q, load_d, under_q, under_d, req_q, req_d;
  logic          frame_start;

  assign frame_start = tick & (bit_q == '0);
  assign take        = frame_start & hold_vld;
  assign req         = req_q;
  assign ser_data    = shift_q[SAMPLE_W-1];
  assign ser_load    = load_q;
  assign underrun    = under_q;

  always_comb begin
    shift_d = shift_q;
    bit_d   = bit_q;
    load_d  = load_q;
    under_d = under_q;
    req_d   = req_q;
    // level request: raised when the held sample is consumed, dropped on acknowledge
    if (take)          req_d = 1'b1;
    else if (hold_vld) req_d = 1'b0;
    if (frame_start) begin
      shift_d = hold_vld ? hold_data : '0;
      load_d  = 1'b1;
      under_d = under_q | ~hold_vld;
      bit_d   = BW'(1);
    end else if (tick) begin
      shift_d = {shift_q[SAMPLE_W-2:0], 1'b0};
      load_d  = 1'b0;
      bit_d   = (bit_q == BW'(SAMPLE_W - 1)) ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bit_q   <= '0;
      load_q  <= 1'b0;
      under_q <= 1'b0;
      req_q   <= 1'b1;
    end else begin
      shift_q <= shift_d;
      bit_q   <= bit_d;
      load_q  <= load_d;
      under_q <= under_d;
      req_q   <= req_d;
    end
  end
endmodule

// File: rtl/dacf_top.sv
module dacf_top
  import dacf_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 3,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                full,
  input  logic                slow_clk,
  output logic                ser_data,
  output logic                ser_load,
  output logic                underrun
);
  logic [1:0]    rst_pipe_q;
  logic          rst_n_s;
  logic          tick, fifo_pop, fifo_empty, hold_vld, take, req;
  sample_t       fifo_head, hold_data;
  logic [CW-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  dacf_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n_s), .async_in(slow_clk), .rise_en(tick)
  );

  dacf_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n_s), .push(wr_en), .push_data(wr_data),
    .pop(fifo_pop), .head(fifo_head), .full(full), .empty(fifo_empty), .fill(fill)
  );

  dacf_fetch fetch_i (
    .clk(clk), .rst_n(rst_n_s), .req(req), .fifo_empty(fifo_empty),
    .fifo_head(fifo_head), .fifo_pop(fifo_pop), .take(take),
    .hold_data(hold_data), .hold_vld(hold_vld)
  );

  dacf_serializer ser_i (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .hold_data(hold_data),
    .hold_vld(hold_vld), .take(take), .req(req), .ser_data(ser_data),
    .ser_load(ser_load), .underrun(underrun)
  );
endmodule

// File: rtl/dacf_checker.sv
module dacf_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          full,
  input logic [CW-1:0] fill,
  input logic          req,
  input logic          hold_vld,
  input logic          pop,
  input logic          ser_data,
  input logic          ser_load,
  input logic          underrun
);
  // R2: serial outputs move only after an enable cycle
  a_r2_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ser_data) && $stable(ser_load)));

  // R4: the strobe lasts one bit period
  a_r4_load_one_period: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_load && tick) |=> !ser_load);

  // R5: underrun is sticky
  a_r5_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R6: occupancy never exceeds the depth
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R7: a write while full with no pop leaves occupancy unchanged
  a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop) |=> $stable(fill));

  // R8: a pending request is held until the holding register fills
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hold_vld) |=> req);

  // R8: every pop lands in the holding register
  a_r8_pop_fills_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> hold_vld);
endmodule

bind dacf_top dacf_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .tick(tick), .wr_en(wr_en), .full(full),
  .fill(fill), .req(req), .hold_vld(hold_vld), .pop(fifo_pop),
  .ser_data(ser_data), .ser_load(ser_load), .underrun(underrun)
);

// File: tb/dacf_top_tb_top.sv
`timescale 1ns/1ps
module dacf_top_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       slow_clk = 1'b0;
  logic       full, ser_data, ser_load, underrun;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit count_loads = 0;
  int load_rises = 0;
  logic prev_load = 1'b0;

  always #2 clk = ~clk;

  dacf_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .slow_clk(slow_clk), .ser_data(ser_data), .ser_load(ser_load), .underrun(underrun)
  );

  // behavioural reference
  logic [7:0] q[$];
  logic [2:0] m_sync;
  logic [7:0] m_hold, m_shift;
  logic       m_hv, m_req, m_load, m_under;
  int         m_bit;
  logic       t_tick, t_take, t_pop, t_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_sync = 3'b000; m_hold = 8'h00; m_shift = 8'h00;
      m_hv = 1'b0; m_req = 1'b1; m_load = 1'b0; m_under = 1'b0; m_bit = 0;
    end else begin
      t_tick = m_sync[1] & ~m_sync[2];
      t_take = t_tick && (m_bit == 0) && m_hv;
      t_pop  = m_req && !m_hv && (q.size() > 0);
      t_acc  = wr_en && (q.size() < DEPTH);
      if (t_tick) begin
        if (m_bit == 0) begin
          m_shift = m_hv ? m_hold : 8'h00;
          if (!m_hv) m_under = 1'b1;
          m_load = 1'b1;
          m_bit = 1;
        end else begin
          m_shift = m_shift << 1;
          m_load = 1'b0;
          m_bit = (m_bit + 1) % 8;
        end
      end
      if (t_take) m_req = 1'b1;
      else if (m_hv) m_req = 1'b0;
      if (t_pop) begin
        m_hold = q.pop_front();
        m_hv = 1'b1;
      end else if (t_take) m_hv = 1'b0;
      if (t_acc) q.push_back(wr_data);
      m_sync = {m_sync[1:0], slow_clk};
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R6 full flag", full, (q.size() == DEPTH));
      check("R2/R3 ser_data", ser_data, m_shift[7]);
      check("R4 ser_load", ser_load, m_load);
      check("R5 underrun", underrun, m_under);
      if (count_loads && ser_load && !prev_load) load_rises++;
      prev_load = ser_load;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic slow_cycle(input int hi, input int lo);
    slow_clk = 1'b1;
    repeat (hi) step();
    slow_clk = 1'b0;
    repeat (lo) step();
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
  end

  initial begin : stim
    repeat (3) step();
    // R1: outputs while reset is held
    check("R1 reset full", full, 1'b0);
    check("R1 reset ser_data", ser_data, 1'b0);
    check("R1 reset ser_load", ser_load, 1'b0);
    check("R1 reset underrun", underrun, 1'b0);
    rst_n = 1'b1;
    repeat (4) step();

    // R6/R8: 17 writes fill FIFO plus holding register
    for (int i = 0; i < 17; i++) do_write(8'(i * 37 + 3));
    step();
    check("R6 full after 17 writes", full, 1'b1);
    // R7: rejected write
    do_write(8'hEE);
    check("R7 full after rejected write", full, 1'b1);
    repeat (5) step();
    check("R8 no pop without request", full, 1'b1);

    // R3/R4: drain 17 frames, 136 bit periods
    count_loads = 1;
    repeat (136) slow_cycle(5, 5);
    repeat (4) step();
    count_loads = 0;
    checks++;
    if (load_rises != 17) begin
      errors++;
      $display("FAIL R4 frame strobes: actual=%0d expected=17", load_rises);
    end
    check("R5 no underrun while fed", underrun, 1'b0);

    // R5: empty at frame start
    repeat (24) slow_cycle(2, 3);
    repeat (4) step();
    check("R5 underrun set", underrun, 1'b1);

    // R2/R3/R5: writes concurrent with an asymmetric slow clock
    fork
      begin repeat (64) slow_cycle(3, 7); end
      begin
        for (int i = 0; i < 6; i++) begin
          repeat (9) step();
          do_write(8'(8'h80 >> i | 8'h01 << i));
        end
      end
    join
    repeat (4) step();
    check("R5 underrun stays set", underrun, 1'b1);

    // R1/R5: reset clears underrun
    rst_n = 1'b0;
    step();
    check("R1 underrun cleared", underrun, 1'b0);
    check("R1 ser_load cleared", ser_load, 1'b0);
    rst_n = 1'b1;
    repeat (6) step();
    summary();
  end
endmodule